// File: doc/BRIEF.md
# Rotate Unit with Extend Flag

This block is the rotate stage of an integer execution pipe. It takes a rotate instruction word, the destination operand, the value of the count register and the current extend flag. One clock later it returns the rotated destination and a fresh set of condition flags (negative, zero, overflow, carry and extend). It handles byte, word and long operands, plain rotates in either direction, and rotates in either direction that pass through the extend flag.

A small decoder inside the block turns the instruction word into control strobes: direction, mode, size and a raw count. The datapath uses these to run the operation. Fetching the instruction, choosing the count register and any memory access happen outside the block. The caller hands over the count register's value and, for the memory form, the fetched word.

Top module: `rotx_unit`

## Requirements
- R1: In plain mode (`opcode[3]`=1) the bit shifted out of one end of the operand comes back in at the other end. The operand width is 8, 16 or 32 bits, chosen by `opcode[7:6]` = 00, 01 or 10.
- R2: In extend mode (`opcode[3]`=0) the operand and X together form a ring of width+1 bits. On a left step the operand MSB moves into X and the old X moves into the LSB. On a right step the operand LSB moves into X and the old X moves into the MSB.
- R3: When `opcode[5]`=1 the count is `countReg[5:0]`. Plain mode reduces it modulo the width. Extend mode reduces it modulo 9, 17 or 33.
- R4: When `opcode[5]`=0 the count is `opcode[11:9]`, and a field value of 0 means a count of 8.
- R5: A register count of 0 leaves the operand and X as they were. Plain mode then clears C, and extend mode then copies the incoming X into C.
- R6: Plain mode never changes X. C is the result LSB after a left rotate and the result MSB after a right rotate.
- R7: In extend mode C and X both take the last bit that entered the X position.
- R8: V is always 0. N is the MSB of the result at the selected size. Z is 1 exactly when the selected-size result is zero.
- R9: For byte and word sizes, the result bits above the operand width equal the operand's own upper bits.
- R10: When `opcode[7:6]`=11 (memory form) the block rotates the low 16 bits by exactly 1, whatever the count fields hold.
- R11: `opcode[8]`=1 selects a left rotate and 0 selects a right rotate.
- R12: `outValid` rises one clock after `inValid` is sampled high, with the result and flags of that operation. Reset clears `outValid`, `result` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opcode | input | 16 | Rotate instruction word |
| operand | input | 32 | Destination register value or memory word |
| countReg | input | 32 | Value of the selected count register |
| xIn | input | 1 | Current extend flag |
| outValid | output | 1 | Result and flags valid |
| result | output | 32 | Rotated destination |
| flagN | output | 1 | Negative |
| flagZ | output | 1 | Zero |
| flagV | output | 1 | Overflow, always 0 |
| flagC | output | 1 | Carry |
| flagX | output | 1 | Extend |

## Verification
The hardest cases to reach are register counts that are nonzero but reduce to zero. Examples are 9, 18, 27 or 36 for a byte rotate through X, and 8, 16 or 32 for a plain byte rotate. These leave the data unchanged but still have to produce the carry of a real rotate, and random counts rarely land on them. The stimulus therefore sweeps every register count from 0 to 63 for each size, mode and direction. It adds directed immediate-zero and memory-form cases, then runs seeded random operations. Every result is compared with a reference that rotates one bit at a time.

// File: rtl/rotx_pkg.sv
package rotx_pkg;
  localparam int OP_W    = 16;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 6;
  localparam int N_SIZES = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } opSize_e;

  typedef struct packed {
    logic             left;
    logic             plain;
    logic             regCount;
    opSize_e          size;
    logic [CNT_W-1:0] count;
  } rotCtrl_t;
endpackage

// File: rtl/rotx_ctrl.sv
module rotx_ctrl
  import rotx_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int DW   = DATA_W,
  parameter int CW   = CNT_W
) (
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  countReg,
  output rotCtrl_t       ctrl
);
  logic       memForm;
  logic [2:0] immField;

  always_comb begin
    memForm  = (opcode[7:6] == 2'b11);
    immField = opcode[11:9];
    ctrl.left     = opcode[8];
    ctrl.plain    = opcode[3];
    ctrl.regCount = opcode[5] && !memForm;
    if (memForm) begin
      ctrl.size  = SZ_WORD;
      ctrl.count = CW'(1);
    end else begin
      ctrl.size = opSize_e'(opcode[7:6]);
      if (opcode[5])
        ctrl.count = countReg[CW-1:0];
      else if (immField == 3'd0)
        ctrl.count = CW'(8);
      else
        ctrl.count = CW'(immField);
    end
  end
endmodule

// File: rtl/rotx_ring.sv
module rotx_ring #(
  parameter int W  = 8,
  parameter int CW = 6
) (
  input  logic [W-1:0]  data,
  input  logic          xIn,
  input  logic          left,
  input  logic [CW-1:0] count,
  output logic [W-1:0]  resPlain,
  output logic [W-1:0]  resExt,
  output logic          xExt
);
  localparam int R = W + 1;

  logic [CW-1:0]  amtPlain;
  logic [CW-1:0]  amtExt;
  logic [2*W-1:0] dblPlain;
  logic [2*W-1:0] shPlain;
  logic [R-1:0]   ring;
  logic [R-1:0]   ringOut;
  logic [2*R-1:0] dblExt;
  logic [2*R-1:0] shExt;

  always_comb begin
    amtPlain = CW'(int'(count) % W);
    amtExt   = CW'(int'(count) % R);
    dblPlain = {data, data};
    ring     = {xIn, data};
    dblExt   = {ring, ring};
    if (left) begin
      shPlain  = dblPlain << amtPlain;
      resPlain = shPlain[2*W-1:W];
      shExt    = dblExt << amtExt;
      ringOut  = shExt[2*R-1:R];
    end else begin
      shPlain  = dblPlain >> amtPlain;
      resPlain = shPlain[W-1:0];
      shExt    = dblExt >> amtExt;
      ringOut  = shExt[R-1:0];
    end
    resExt = ringOut[W-1:0];
    xExt   = ringOut[W];
  end
endmodule

// File: rtl/rotx_datapath.sv
module rotx_datapath
  import rotx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int NS = N_SIZES
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  rotCtrl_t      ctrl,
  input  logic [DW-1:0] operand,
  input  logic          xIn,
  output logic          outValid,
  output logic [DW-1:0] result,
  output logic          flagN,
  output logic          flagZ,
  output logic          flagV,
  output logic          flagC,
  output logic          flagX
);
  logic [DW-1:0] resPlainArr [NS];
  logic [DW-1:0] resExtArr   [NS];
  logic          xExtArr     [NS];

  for (genvar gi = 0; gi < NS; gi++) begin : g_size
    localparam int W = 8 << gi;
    logic [W-1:0] rp;
    logic [W-1:0] re;
    logic         xe;
    rotx_ring #(.W(W), .CW(CW)) u_ring (
      .data     (operand[W-1:0]),
      .xIn      (xIn),
      .left     (ctrl.left),
      .count    (ctrl.count),
      .resPlain (rp),
      .resExt   (re),
      .xExt     (xe)
    );
    assign resPlainArr[gi] = DW'(rp);
    assign resExtArr[gi]   = DW'(re);
    assign xExtArr[gi]     = xe;
  end

  logic [1:0]    sel;
  logic [DW-1:0] sizedRes;
  logic [DW-1:0] mergedRes;
  logic          msbBit;
  logic          lsbBit;
  logic          zeroBit;
  logic          carryNext;
  logic          extNext;

  always_comb begin
    sel       = (ctrl.size == SZ_LONG) ? 2'd2 : (ctrl.size == SZ_WORD) ? 2'd1 : 2'd0;
    sizedRes  = ctrl.plain ? resPlainArr[sel] : resExtArr[sel];
    lsbBit    = sizedRes[0];
    unique case (sel)
      2'd0: begin
        msbBit    = sizedRes[7];
        zeroBit   = (sizedRes[7:0] == 8'd0);
        mergedRes = {operand[DW-1:8], sizedRes[7:0]};
      end
      2'd1: begin
        msbBit    = sizedRes[15];
        zeroBit   = (sizedRes[15:0] == 16'd0);
        mergedRes = {operand[DW-1:16], sizedRes[15:0]};
      end
      default: begin
        msbBit    = sizedRes[DW-1];
        zeroBit   = (sizedRes == '0);
        mergedRes = sizedRes;
      end
    endcase
    if (ctrl.plain) begin
      extNext   = xIn;
      if (ctrl.count == '0)
        carryNext = 1'b0;
      else
        carryNext = ctrl.left ? lsbBit : msbBit;
    end else begin
      extNext   = xExtArr[sel];
      carryNext = xExtArr[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
      flagC    <= 1'b0;
      flagX    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result <= mergedRes;
        flagN  <= msbBit;
        flagZ  <= zeroBit;
        flagV  <= 1'b0;
        flagC  <= carryNext;
        flagX  <= extNext;
      end
    end
  end
endmodule

// File: rtl/rotx_unit.sv
module rotx_unit
  import rotx_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int DW  = DATA_W,
  parameter int CW  = CNT_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  operand,
  input  logic [DW-1:0]  countReg,
  input  logic           xIn,
  output logic           outValid,
  output logic [DW-1:0]  result,
  output logic           flagN,
  output logic           flagZ,
  output logic           flagV,
  output logic           flagC,
  output logic           flagX
);
  rotCtrl_t ctrl;

  rotx_ctrl #(.OPW(OPW), .DW(DW), .CW(CW)) u_ctrl (
    .opcode   (opcode),
    .countReg (countReg),
    .ctrl     (ctrl)
  );

  rotx_datapath #(.DW(DW), .CW(CW), .NS(N_SIZES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .operand  (operand),
    .xIn      (xIn),
    .outValid (outValid),
    .result   (result),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagV    (flagV),
    .flagC    (flagC),
    .flagX    (flagX)
  );
endmodule

// File: rtl/rotx_unit_chk.sv
module rotx_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [15:0] opcode,
  input logic [31:0] operand,
  input logic [31:0] countReg,
  input logic        xIn,
  input logic        outValid,
  input logic [31:0] result,
  input logic        flagV,
  input logic        flagC,
  input logic        flagX
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid) |-> outValid); // R12
  AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !flagV); // R8
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opcode[7:6]) == 2'b00) |-> result[31:8] == $past(operand[31:8])); // R9
  AST_WORD_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opcode[7:6]) == 2'b01) |-> result[31:16] == $past(operand[31:16])); // R9
  AST_PLAIN_KEEPS_X: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opcode[3])) |-> flagX == $past(xIn)); // R6
  AST_EXT_C_EQ_X: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && !$past(opcode[3])) |-> flagC == flagX); // R7
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opcode[5]) && $past(opcode[7:6]) != 2'b11 &&
     $past(countReg[5:0]) == 6'd0) |-> (result == $past(operand) && flagX == $past(xIn))); // R5
endmodule

bind rotx_unit rotx_unit_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opcode   (opcode),
  .operand  (operand),
  .countReg (countReg),
  .xIn      (xIn),
  .outValid (outValid),
  .result   (result),
  .flagV    (flagV),
  .flagC    (flagC),
  .flagX    (flagX)
);

// File: tb/rotx_unit_bench.sv
module rotx_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] operand = '0;
  logic [31:0] countReg = '0;
  logic        xIn = 1'b0;
  logic        outValid;
  logic [31:0] result;
  logic        flagN, flagZ, flagV, flagC, flagX;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rotx_unit u_rotx_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .operand(operand), .countReg(countReg), .xIn(xIn),
    .outValid(outValid), .result(result), .flagN(flagN), .flagZ(flagZ),
    .flagV(flagV), .flagC(flagC), .flagX(flagX)
  );

  function automatic logic [15:0] mkOp(input logic left, input logic plain,
      input logic [1:0] sz, input logic useReg, input logic [2:0] fld);
    return {4'hE, fld, left, sz, useReg, 1'b1, plain, 3'b000};
  endfunction

  // bit-serial reference: returns {result, N, Z, V, C, X}
  function automatic logic [36:0] refModel(input logic [15:0] op, input logic [31:0] opd,
      input logic [31:0] creg, input logic x);
    int w;
    int cnt;
    logic [31:0] msk;
    logic [31:0] d;
    logic xx, c, b, n, z;
    logic mem;
    mem = (op[7:6] == 2'b11);
    w   = mem ? 16 : (op[7:6] == 2'b00) ? 8 : (op[7:6] == 2'b01) ? 16 : 32;
    if (mem) cnt = 1;
    else if (op[5]) cnt = int'(creg[5:0]);
    else cnt = (op[11:9] == 3'd0) ? 8 : int'(op[11:9]);
    msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    d = opd & msk;
    xx = x;
    for (int i = 0; i < cnt; i++) begin
      if (op[8]) begin
        b = d[w-1];
        d = ((d << 1) | {31'd0, (op[3] ? b : xx)}) & msk;
        if (!op[3]) xx = b;
      end else begin
        b = d[0];
        d = (d >> 1) | ({31'd0, (op[3] ? b : xx)} << (w - 1));
        if (!op[3]) xx = b;
      end
    end
    if (op[3]) c = (cnt == 0) ? 1'b0 : (op[8] ? d[0] : d[w-1]);
    else c = xx;
    n = d[w-1];
    z = (d == 32'd0);
    return {(opd & ~msk) | d, n, z, 1'b0, c, xx};
  endfunction

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic runOp(input logic [15:0] op, input logic [31:0] opd,
      input logic [31:0] creg, input logic x, input string req);
    logic [36:0] exp;
    logic [36:0] act;
    @(negedge clk);
    opcode = op; operand = opd; countReg = creg; xIn = x; inValid = 1'b1;
    exp = refModel(op, opd, creg, x);
    @(negedge clk);
    inValid = 1'b0;
    act = {result, flagN, flagZ, flagV, flagC, flagX};
    checks++;
    if (!outValid || act !== exp) begin
      errors++;
      $display("FAIL %s op=%h opd=%h cnt=%0d x=%b actual=%h/%b expected=%h/%b valid=%b",
               req, op, opd, creg[5:0], x, act[36:5], act[4:0], exp[36:5], exp[4:0], outValid);
    end
  endtask

  task automatic checkLit(input logic [31:0] expRes, input logic [4:0] expFl, input string req);
    checks++;
    if (result !== expRes || {flagN, flagZ, flagV, flagC, flagX} !== expFl) begin
      errors++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", req, result,
               {flagN, flagZ, flagV, flagC, flagX}, expRes, expFl);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired R12");
      report();
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (outValid !== 1'b0 || result !== 32'd0 || {flagN, flagZ, flagV, flagC, flagX} !== 5'd0) begin
      errors++;
      $display("FAIL R12 reset actual=%b/%h/%b expected=0/0/0", outValid, result,
               {flagN, flagZ, flagV, flagC, flagX});
    end
    rstN = 1'b1;

    // R7 / R2: byte left through X, 0x80 x=0 by 1 -> 0x00, C=X=1, Z=1
    runOp(mkOp(1'b1, 1'b0, 2'b00, 1'b0, 3'd1), 32'hAAAA_AA80, 32'd0, 1'b0, "R7");
    checkLit(32'hAAAA_AA00, 5'b01011, "R7 literal");
    // R2: byte right through X, 0x01 x=1 by 1 -> 0x80, C=X=1, N=1
    runOp(mkOp(1'b0, 1'b0, 2'b00, 1'b0, 3'd1), 32'h0000_0001, 32'd0, 1'b1, "R2");
    checkLit(32'h0000_0080, 5'b10011, "R2 literal");
    // R1 / R6: plain word left 0x8001 by 1 -> 0x0003, C=1, X kept
    runOp(mkOp(1'b1, 1'b1, 2'b01, 1'b0, 3'd1), 32'h1234_8001, 32'd0, 1'b0, "R1");
    checkLit(32'h1234_0003, 5'b00010, "R6 literal");
    // R4: immediate field 0 means 8; plain byte rotate by 8 leaves value
    runOp(mkOp(1'b1, 1'b1, 2'b00, 1'b0, 3'd0), 32'h0000_00C3, 32'd0, 1'b1, "R4");
    checkLit(32'h0000_00C3, 5'b10011, "R4 literal");
    // R5: zero register count, extend mode, C takes X
    runOp(mkOp(1'b0, 1'b0, 2'b10, 1'b1, 3'd2), 32'h8000_0000, 32'h0000_0040, 1'b1, "R5");
    checkLit(32'h8000_0000, 5'b10011, "R5 literal");
    // R5: zero register count, plain mode clears C
    runOp(mkOp(1'b1, 1'b1, 2'b00, 1'b1, 3'd2), 32'h0000_0001, 32'h0000_0000, 1'b0, "R5");
    checkLit(32'h0000_0001, 5'b00000, "R5 plain literal");
    // R10: memory form rotates word by one regardless of fields
    runOp({4'hE, 3'd5, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 3'b0}, 32'hFFFF_4000, 32'd7, 1'b0, "R10");
    checkLit(32'hFFFF_8000, 5'b10000, "R10 literal");
    runOp({4'hE, 3'd0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 3'b0}, 32'h0000_0001, 32'd0, 1'b0, "R10");
    // R3 / R11: full register count sweep
    for (int sz = 0; sz < 3; sz++)
      for (int pl = 0; pl < 2; pl++)
        for (int lf = 0; lf < 2; lf++)
          for (int c = 0; c < 64; c++)
            runOp(mkOp(lf[0], pl[0], sz[1:0], 1'b1, 3'd3), $urandom(), {$urandom() & 32'hFFFF_FFC0} | c,
                  c[0], "R3 R11 sweep");
    // R8 / R9: random mix including memory form
    for (int i = 0; i < 1500; i++)
      runOp($urandom() & 32'hFFFF, $urandom(), $urandom(), $urandom() % 2 == 1, "R8 R9 random");
    // R8: zero-result flag case
    runOp(mkOp(1'b0, 1'b1, 2'b01, 1'b0, 3'd3), 32'hFFFF_0000, 32'd0, 1'b1, "R8");
    done = 1'b1;
    report();
    $finish;
  end
endmodule